// File: doc/BRIEF.md
# Programmable One-Shot/Periodic Timer Channel

This block is a single countdown timer channel with a small 32-bit register interface. Software programs a preset and a mode into one control word. The channel then counts the preset down, one step per microsecond tick, and the tick is derived from the system clock by a divider. When the count would pass zero the channel expires. Expiry sets a pending flag, and that flag drives a level-high interrupt until software clears it through the status register. In one-shot mode the channel then disables itself. In periodic mode it reloads the preset in the same tick and keeps running.

Each expiry is also exported as a one-cycle pulse, together with a constant channel index. A watchdog placed next to the channel can use the pulse as its tick source and the index to identify the channel.

Registers are written with a single-cycle write strobe. Reads are combinational from the address. The registers are a control word at offset 0x0, a status word at offset 0x4 and a tick-source select at offset 0x8.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `irq` and `expire_pulse` are low, and the control, status and source registers all read as zero.
- R2: The control register at offset 0x0 holds the enable in bit 31, the periodic-mode select in bit 30 and a 28-bit preset in bits 27:0. It reads back as written, and bits 29:28 always read 0.
- R3: A control write with bit 31 set loads the preset and restarts the tick divider. With preset P and a divide ratio D, the first expiry appears at the clock edge (P+1)*D cycles after the write edge.
- R4: In one-shot mode (bit 30 = 0), expiry clears the enable. Status bit 29 then reads 0, and no further expiry occurs.
- R5: In periodic mode (bit 30 = 1), the counter reloads the preset on expiry. Expiries then repeat every (P+1)*D cycles for as long as the channel stays enabled.
- R6: `irq` is active high and stays asserted until a write to the status register at offset 0x4 has bit 30 set. A status write with bit 30 clear has no effect. Status bit 30 reads the pending flag.
- R7: When a clear write and a new expiry fall in the same cycle, the pending flag stays set.
- R8: Writing 0 to the control register disables the channel, and no further expiry occurs.
- R9: The 4-bit tick-source register at offset 0x8 selects the microsecond tick when it holds 0. Any nonzero value halts counting, and counting resumes from the held count once the register returns to 0.
- R10: `expire_pulse` is high for exactly one cycle, on the same edge that sets the pending flag. `chan_idx` always equals the `CHAN_ID` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Level-high interrupt, driven by the pending flag |
| expire_pulse | output | 1 | One-cycle pulse on each expiry |
| chan_idx | output | IDX_W | Constant channel index |

## Verification
Two functions can fall in the same cycle: software clearing the interrupt and the counter expiring again. The bench runs a periodic channel with preset 0 and times a status clear write so that it lands on the same edge as the second expiry. It then checks that `irq` is still high and that `expire_pulse` fired. A clear one cycle later must drop `irq`, and the third expiry must raise it again at the predicted edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int unsigned ADDR_W    = 4;
  localparam logic [3:0]  OFS_CTRL  = 4'h0;
  localparam logic [3:0]  OFS_STAT  = 4'h4;
  localparam logic [3:0]  OFS_SRC   = 4'h8;
  localparam int unsigned PRESET_W  = 28;
  localparam int unsigned CNT_W     = 29;
  localparam int unsigned SRC_W     = 4;
  localparam int unsigned CTL_EN_B  = 31;
  localparam int unsigned CTL_PER_B = 30;
  localparam int unsigned ST_PEND_B = 30;
  localparam int unsigned ST_RUN_B  = 29;

  typedef struct packed {
    logic                en;
    logic                per;
    logic [PRESET_W-1:0] preset;
  } ctrl_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic gate_on,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    tick = gate_on && (pre_q == LAST);
    if (restart || (pre_q == LAST)) pre_d = '0;
    else                            pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_wr,
  input  ctrl_t ctrl_wdata,
  input  logic  stat_clr,
  input  logic  tick,
  output ctrl_t ctrl_q,
  output logic  pend_q,
  output logic  expire_q
);
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_d, hit;

  always_comb begin
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    hit    = 1'b0;
    if (ctrl_wr) begin
      ctrl_d = ctrl_wdata;
      if (ctrl_wdata.en) cnt_d = CNT_W'(ctrl_wdata.preset);
    end else if (tick && ctrl_q.en) begin
      if (cnt_q == '0) begin
        hit = 1'b1;
        if (ctrl_q.per) cnt_d = CNT_W'(ctrl_q.preset);
        else            ctrl_d.en = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (hit)           pend_d = 1'b1;
    else if (stat_clr) pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      cnt_q    <= cnt_d;
      pend_q   <= pend_d;
      expire_q <= hit;
    end
  end

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(stat_clr));
  // R7
  clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> pend_q);
  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_q && !ctrl_q.per) |-> !ctrl_q.en);
  // R3
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata.en) |=>
      (ctrl_q.en && cnt_q == CNT_W'($past(ctrl_wdata.preset))));
endmodule

// File: rtl/tmr_reg_if.sv
module tmr_reg_if
  import tmr_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  ctrl_t             ctrl_q,
  input  logic              pend_q,
  output logic              ctrl_wr,
  output ctrl_t             ctrl_wdata,
  output logic              stat_clr,
  output logic [SRC_W-1:0]  src_q,
  output logic [31:0]       bus_rdata
);
  logic [SRC_W-1:0] src_d;
  logic             src_wr;
  logic             unused_bits;

  assign unused_bits = ^bus_wdata[29:28];

  always_comb begin
    ctrl_wr           = bus_wr && (bus_addr == OFS_CTRL);
    src_wr            = bus_wr && (bus_addr == OFS_SRC);
    stat_clr          = bus_wr && (bus_addr == OFS_STAT) && bus_wdata[ST_PEND_B];
    ctrl_wdata.en     = bus_wdata[CTL_EN_B];
    ctrl_wdata.per    = bus_wdata[CTL_PER_B];
    ctrl_wdata.preset = bus_wdata[PRESET_W-1:0];
    src_d             = src_wr ? bus_wdata[SRC_W-1:0] : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[CTL_EN_B]       = ctrl_q.en;
        bus_rdata[CTL_PER_B]      = ctrl_q.per;
        bus_rdata[PRESET_W-1:0]   = ctrl_q.preset;
      end
      OFS_STAT: begin
        bus_rdata[ST_PEND_B] = pend_q;
        bus_rdata[ST_RUN_B]  = ctrl_q.en;
      end
      OFS_SRC:  bus_rdata[SRC_W-1:0] = src_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R9
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_wr |=> (src_q == $past(src_q)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_chan_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 250,
  parameter int unsigned CHAN_ID      = 0,
  parameter int unsigned IDX_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              expire_pulse,
  output logic [IDX_W-1:0]  chan_idx
);
  logic             rst_s1, rst_sn;
  logic             ctrl_wr, stat_clr, tick;
  ctrl_t            ctrl_wdata, ctrl_q;
  logic             pend_q, expire_q;
  logic [SRC_W-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  tmr_reg_if u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ctrl_q     (ctrl_q),
    .pend_q     (pend_q),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .stat_clr   (stat_clr),
    .src_q      (src_q),
    .bus_rdata  (bus_rdata)
  );

  tmr_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sn),
    .restart (ctrl_wr && ctrl_wdata.en),
    .gate_on (src_q == '0),
    .tick    (tick)
  );

  tmr_count_core u_core (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .stat_clr   (stat_clr),
    .tick       (tick),
    .ctrl_q     (ctrl_q),
    .pend_q     (pend_q),
    .expire_q   (expire_q)
  );

  assign irq          = pend_q;
  assign expire_pulse = expire_q;
  assign chan_idx     = IDX_W'(CHAN_ID);

  // R9
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (src_q != '0) |-> !tick);
  // R10
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !$past(ctrl_q.en) |-> !expire_pulse);
endmodule

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
  localparam int unsigned DIV = 4;
  localparam int unsigned CID = 5;

  typedef struct packed {
    logic [27:0] preset;
    logic [15:0] cycles;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{28'd0, 16'd4}, '{28'd1, 16'd8}, '{28'd2, 16'd12}, '{28'd6, 16'd28}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, expire_pulse;
  logic [3:0]  chan_idx;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  tmr_channel #(.CLK_PER_TICK(DIV), .CHAN_ID(CID), .IDX_W(4)) i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .expire_pulse(expire_pulse), .chan_idx(chan_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pulse", {31'd0, expire_pulse}, 32'd0);
    rd(4'h0, rv); chk("R1 ctrl", rv, 32'd0);
    rd(4'h4, rv); chk("R1 stat", rv, 32'd0);
    rd(4'h8, rv); chk("R1 src", rv, 32'd0);
    chk("R10 chan_idx", {28'd0, chan_idx}, CID);

    // R2 readback and reserved bits
    wr(4'h0, 32'h3FFF_FFFF);
    rd(4'h0, rv); chk("R2 readback", rv, 32'h0FFF_FFFF);
    wr(4'h0, 32'h7123_4567);
    rd(4'h0, rv); chk("R2 periodic bit", rv, 32'h4123_4567);
    wr(4'h0, 32'h0);

    // R3/R4 one-shot vectors
    for (int i = 0; i < 4; i++) begin
      wr(4'h0, 32'h8000_0000 | {4'd0, VECS[i].preset});
      waitn(int'(VECS[i].cycles) - 1);
      chk("R3 not early", {31'd0, irq}, 32'd0);
      waitn(1);
      chk("R3 expiry edge", {31'd0, irq}, 32'd1);
      chk("R10 pulse on expiry", {31'd0, expire_pulse}, 32'd1);
      rd(4'h4, rv); chk("R4 status after one-shot", rv, 32'h4000_0000);
      waitn(1);
      chk("R10 pulse one cycle", {31'd0, expire_pulse}, 32'd0);
      wr(4'h4, 32'h4000_0000);
      chk("R6 clear", {31'd0, irq}, 32'd0);
      waitn(2 * int'(VECS[i].cycles));
      chk("R4 no re-expiry", {31'd0, irq}, 32'd0);
    end

    // R5/R6/R7 periodic, preset 0: expiries at E4, E8, E12
    wr(4'h0, 32'hC000_0000);                  // E0
    waitn(3);
    chk("R5 before first", {31'd0, irq}, 32'd0);
    waitn(1);
    chk("R5 first expiry", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'hBFFF_FFFF);                  // E5, bit30 clear
    chk("R6 no-clear write ignored", {31'd0, irq}, 32'd1);
    waitn(2);
    wr(4'h4, 32'h4000_0000);                  // E8, collides with expiry
    chk("R7 clear vs expiry", {31'd0, irq}, 32'd1);
    chk("R5 second expiry pulse", {31'd0, expire_pulse}, 32'd1);
    wr(4'h4, 32'h4000_0000);                  // E9
    chk("R6 clear after race", {31'd0, irq}, 32'd0);
    waitn(2);
    chk("R5 before third", {31'd0, irq}, 32'd0);
    waitn(1);
    chk("R5 third expiry", {31'd0, irq}, 32'd1);

    // R8 disable
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h4000_0000);
    waitn(20);
    chk("R8 no expiry after disable", {31'd0, irq}, 32'd0);
    rd(4'h4, rv); chk("R8 status idle", rv, 32'd0);

    // R9 tick source select
    wr(4'h8, 32'h1);
    rd(4'h8, rv); chk("R9 src readback", rv, 32'h1);
    wr(4'h0, 32'h8000_0000);
    waitn(20);
    chk("R9 halted", {31'd0, irq}, 32'd0);
    wr(4'h8, 32'h0);
    waitn(6);
    chk("R9 resumed", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h4000_0000);
    chk("R6 final clear", {31'd0, irq}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule